// File: doc/BRIEF.md
# Adaptive Multi-Interval Single-Slope Conversion Sequencer

This block is the digital controller for one shared pixel conversion cell. Each pixel time slot opens with a reset phase, in which the integrator node is cleared and both conversion latches are preset high. Integration follows, and the analog comparator is consulted at five points spaced in binary steps of the maximum integration time: one sixteenth, one eighth, one quarter, one half, and the full span. The first check that sees the integrated level above the threshold stops integration and holds the level. It also switches the comparator reference over to the global ramp. When the ramp reaches the held level, the value of the shared ramp counter is captured and analog power is removed for the rest of the slot. If no check ever sees a crossing, the level at the full span is held anyway and a last-phase ramp conversion runs.

The captured count is paired with the index of the check that ended integration, so downstream logic can scale the count by 2^(4-index). The result leaves the cell through a valid/ready output stream. That stream is opened only while the row read strobe is high. The slot timing comes from a global slot timer, and the comparator is sampled only on the clock edges where the timer sits on a check point. Pulses on the comparator between check points therefore cannot end integration.

Top module: `mss_conv_seq`

## Requirements
- R1: After rst_n, and in the cycle after any edge with slot_start high, latch1_n and latch2_n read 1. Starting from a slot_start edge, int_rst is high and analog_pwr is high until the edge where slot_time equals RST_CYC.
- R2: During integration, chk_en is high exactly in the cycles where slot_time equals RST_CYC + TM_CYC/16, /8, /4, /2 and /1. Those five points are visited in that order, and chk_en is never high outside integration.
- R3: cmp_out is ignored during integration except on check-point edges. High pulses between check points leave latch1_n at 1 and int_run at 1.
- R4: The first check-point edge with cmp_out high drops latch1_n to 0 until the next slot_start, and it ends int_run. From the next cycle ref_ramp is high. The interval index recorded is 0, 1, 2, 3 or 4 for the checks at TM_CYC/16, /8, /4, /2 and TM_CYC respectively.
- R5: If cmp_out is low at all five checks, integration ends at the full-span check anyway. ref_ramp and last_phase are then high with latch1_n still 1, and the index recorded is 4.
- R6: During the ramp phase, the first edge with cmp_out high stores ramp_count into the result and drops latch2_n to 0 in the next cycle. latch2_n stays 0 until the next slot_start.
- R7: If ramp_count reaches all ones during the ramp phase without cmp_out high, the value all ones is stored, and the conversion ends on that edge.
- R8: From the cycle after capture until the next slot_start, analog_pwr is 0.
- R9: res_valid is high only while a captured result is held and row_read is high. While res_ready is low, res_count and res_interval stay unchanged. A transfer (res_valid and res_ready on one edge) consumes the result, so res_valid then stays low.
- R10: slot_start discards any held result that has not been read.
- R11: latch2_n cannot fall during reset or integration; it falls only from the ramp phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_start | input | 1 | Pulse that opens a new pixel slot |
| slot_time | input | TW | Global slot timer, cycles since slot start |
| cmp_out | input | 1 | Comparator output, 1 = input above reference |
| ramp_count | input | CNT_W | Shared ramp counter value |
| row_read | input | 1 | Row read strobe, opens the result stream |
| res_ready | input | 1 | Stream ready from the column side |
| int_rst | output | 1 | Drives the integrator to its reset level |
| int_run | output | 1 | Integration switch closed |
| chk_en | output | 1 | Threshold check enable for comparator and latch 1 |
| ref_ramp | output | 1 | Comparator reference set to the ramp |
| last_phase | output | 1 | Ramp phase entered without a crossing |
| analog_pwr | output | 1 | Power enable for integrator and comparator |
| latch1_n | output | 1 | Threshold latch, 1 until a crossing |
| latch2_n | output | 1 | Ramp latch, 1 until capture |
| res_valid | output | 1 | Result stream valid |
| res_count | output | CNT_W | Captured count |
| res_interval | output | 3 | Interval index 0..4 |

## Verification
The bench builds the block with RST_CYC = 3 and TM_CYC = 64, which puts the five check points at slot_time 7, 11, 19, 35 and 67. With these values each integration path, including the fallback, ends within about seventy cycles. CNT_W keeps its default of 12. Because the bench drives the counter itself, the saturating ramp at 4095 is reachable in one slot of a few thousand cycles, alongside a zero-count capture on the first ramp cycle.

// File: rtl/mss_pkg.sv
package mss_pkg;
  localparam int NCHK  = 5;
  localparam int IDX_W = 3;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RST  = 3'd1,
    PH_INT  = 3'd2,
    PH_RAMP = 3'd3,
    PH_DONE = 3'd4
  } phase_e;
endpackage

// File: rtl/mss_chk_decode.sv
module mss_chk_decode #(
  parameter int TW      = 16,
  parameter int RST_CYC = 4,
  parameter int TM_CYC  = 1024
) (
  input  logic [TW-1:0]            slot_time,
  output logic [mss_pkg::NCHK-1:0] hit
);
  // check k sits at RST_CYC + TM_CYC / 2^(NCHK-1-k)
  for (genvar k = 0; k < mss_pkg::NCHK; k++) begin : g_pt
    localparam int PT = RST_CYC + (TM_CYC >> (mss_pkg::NCHK - 1 - k));
    assign hit[k] = (slot_time == TW'(PT));
  end
endmodule

// File: rtl/mss_phase_ctl.sv
module mss_phase_ctl
  import mss_pkg::*;
#(
  parameter int TW      = 16,
  parameter int CNT_W   = 12,
  parameter int RST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_start,
  input  logic [TW-1:0]    slot_time,
  input  logic             cmp_out,
  input  logic [CNT_W-1:0] ramp_count,
  input  logic [NCHK-1:0]  hit,
  output phase_e           phase,
  output logic             chk_fire,
  output logic             l1_n,
  output logic             l2_n,
  output logic             cap_fire,
  output logic [IDX_W-1:0] idx
);
  logic             chk_any;
  logic [IDX_W-1:0] chk_idx;

  always_comb begin
    chk_any = 1'b0;
    chk_idx = '0;
    for (int k = 0; k < NCHK; k++) begin
      if (hit[k]) begin
        chk_any = 1'b1;
        chk_idx = IDX_W'(k);
      end
    end
  end

  assign chk_fire = (phase == PH_INT) && chk_any;
  assign cap_fire = (phase == PH_RAMP) && (cmp_out || (&ramp_count));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      l1_n  <= 1'b1;
      l2_n  <= 1'b1;
      idx   <= '0;
    end else if (slot_start) begin
      phase <= PH_RST;
      l1_n  <= 1'b1;
      l2_n  <= 1'b1;
      idx   <= '0;
    end else begin
      unique case (phase)
        PH_RST: if (slot_time == TW'(RST_CYC)) phase <= PH_INT;
        PH_INT: begin
          if (chk_any && cmp_out) begin
            l1_n  <= 1'b0;
            idx   <= chk_idx;
            phase <= PH_RAMP;
          end else if (hit[NCHK-1]) begin
            idx   <= chk_idx;
            phase <= PH_RAMP;
          end
        end
        PH_RAMP: if (cap_fire) begin
          l2_n  <= 1'b0;
          phase <= PH_DONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mss_result_buf.sv
module mss_result_buf #(
  parameter int CNT_W = 12,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_start,
  input  logic             cap_fire,
  input  logic [CNT_W-1:0] cap_count,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic             row_read,
  input  logic             res_ready,
  output logic             res_valid,
  output logic [CNT_W-1:0] res_count,
  output logic [IDX_W-1:0] res_interval
);
  logic held;

  assign res_valid = held && row_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held         <= 1'b0;
      res_count    <= '0;
      res_interval <= '0;
    end else if (slot_start) begin
      held <= 1'b0;
    end else if (cap_fire) begin
      held         <= 1'b1;
      res_count    <= cap_count;
      res_interval <= cap_idx;
    end else if (res_valid && res_ready) begin
      held <= 1'b0;
    end
  end
endmodule

// File: rtl/mss_conv_seq.sv
module mss_conv_seq
  import mss_pkg::*;
#(
  parameter int TW      = 16,
  parameter int CNT_W   = 12,
  parameter int RST_CYC = 4,
  parameter int TM_CYC  = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_start,
  input  logic [TW-1:0]    slot_time,
  input  logic             cmp_out,
  input  logic [CNT_W-1:0] ramp_count,
  input  logic             row_read,
  input  logic             res_ready,
  output logic             int_rst,
  output logic             int_run,
  output logic             chk_en,
  output logic             ref_ramp,
  output logic             last_phase,
  output logic             analog_pwr,
  output logic             latch1_n,
  output logic             latch2_n,
  output logic             res_valid,
  output logic [CNT_W-1:0] res_count,
  output logic [IDX_W-1:0] res_interval
);
  phase_e           phase;
  logic [NCHK-1:0]  hit;
  logic             cap_fire;
  logic [IDX_W-1:0] idx;

  mss_chk_decode #(.TW(TW), .RST_CYC(RST_CYC), .TM_CYC(TM_CYC)) u_dec (
    .slot_time(slot_time),
    .hit      (hit)
  );

  mss_phase_ctl #(.TW(TW), .CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_start(slot_start),
    .slot_time (slot_time),
    .cmp_out   (cmp_out),
    .ramp_count(ramp_count),
    .hit       (hit),
    .phase     (phase),
    .chk_fire  (chk_en),
    .l1_n      (latch1_n),
    .l2_n      (latch2_n),
    .cap_fire  (cap_fire),
    .idx       (idx)
  );

  mss_result_buf #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_start  (slot_start),
    .cap_fire    (cap_fire),
    .cap_count   (ramp_count),
    .cap_idx     (idx),
    .row_read    (row_read),
    .res_ready   (res_ready),
    .res_valid   (res_valid),
    .res_count   (res_count),
    .res_interval(res_interval)
  );

  assign int_rst    = (phase == PH_RST);
  assign int_run    = (phase == PH_INT);
  assign ref_ramp   = (phase == PH_RAMP);
  assign last_phase = ref_ramp && latch1_n;
  assign analog_pwr = int_rst || int_run || ref_ramp;
endmodule

// File: rtl/mss_conv_seq_chk.sv
module mss_conv_seq_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_start,
  input logic             cmp_out,
  input logic [CNT_W-1:0] ramp_count,
  input logic             row_read,
  input logic             res_ready,
  input logic             int_rst,
  input logic             int_run,
  input logic             chk_en,
  input logic             ref_ramp,
  input logic             last_phase,
  input logic             analog_pwr,
  input logic             latch1_n,
  input logic             latch2_n,
  input logic             res_valid,
  input logic [CNT_W-1:0] res_count,
  input logic [2:0]       res_interval
);
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_rst, int_run, ref_ramp})); // R1
  AST_CHK_IN_INT: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> int_run); // R2
  AST_L1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch1_n && !slot_start) |=> !latch1_n); // R4
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_interval <= 3'd4)); // R4
  AST_LAST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    last_phase |-> (ref_ramp && latch1_n)); // R5
  AST_L2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch2_n && !slot_start) |=> !latch2_n); // R6
  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch2_n) |-> (res_count == $past(ramp_count))); // R6
  AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(latch2_n) && !$past(cmp_out)) |-> (&res_count)); // R7
  AST_PWR_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    !latch2_n |-> !analog_pwr); // R8
  AST_VALID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> row_read); // R9
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !slot_start) |=>
      ($stable(res_count) && $stable(res_interval))); // R9
  AST_L2_FROM_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch2_n) |-> $past(ref_ramp)); // R11
endmodule

bind mss_conv_seq mss_conv_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .cmp_out(cmp_out),
  .ramp_count(ramp_count), .row_read(row_read), .res_ready(res_ready),
  .int_rst(int_rst), .int_run(int_run), .chk_en(chk_en), .ref_ramp(ref_ramp),
  .last_phase(last_phase), .analog_pwr(analog_pwr), .latch1_n(latch1_n),
  .latch2_n(latch2_n), .res_valid(res_valid), .res_count(res_count),
  .res_interval(res_interval)
);

// File: tb/mss_conv_seq_test.sv
`timescale 1ns/100ps
module mss_conv_seq_test;
  localparam int TW = 16, CNT_W = 12, RST = 3, TM = 64;
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, slot_start = 1'b0, cmp_out = 1'b0;
  logic row_read = 1'b0, res_ready = 1'b0;
  logic [TW-1:0]    slot_time = '0;
  logic [CNT_W-1:0] ramp_count = '0;
  logic int_rst, int_run, chk_en, ref_ramp, last_phase, analog_pwr;
  logic latch1_n, latch2_n, res_valid;
  logic [CNT_W-1:0] res_count;
  logic [2:0] res_interval;

  int n_chk = 0, n_fail = 0;
  int exp_cnt_q[$];
  int exp_idx_q[$];

  always #2.5 clk = ~clk;

  mss_conv_seq #(.TW(TW), .CNT_W(CNT_W), .RST_CYC(RST), .TM_CYC(TM)) uut (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .slot_time(slot_time),
    .cmp_out(cmp_out), .ramp_count(ramp_count), .row_read(row_read),
    .res_ready(res_ready), .int_rst(int_rst), .int_run(int_run), .chk_en(chk_en),
    .ref_ramp(ref_ramp), .last_phase(last_phase), .analog_pwr(analog_pwr),
    .latch1_n(latch1_n), .latch2_n(latch2_n), .res_valid(res_valid),
    .res_count(res_count), .res_interval(res_interval)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cp(input int k);
    return RST + (TM >> (4 - k));
  endfunction

  function automatic bit is_cp(input int t);
    for (int k = 0; k < 5; k++) if (t == cp(k)) return 1'b1;
    return 1'b0;
  endfunction

  // monitor: pops the scoreboard on every stream transfer
  always @(negedge clk) begin
    #2;
    if (rst_n && res_valid && res_ready) begin
      if (exp_cnt_q.size() == 0) check("R9 unexpected transfer", 1, 0);
      else begin
        check("R6 result count", int'(res_count), exp_cnt_q.pop_front());
        check("R4 interval index", int'(res_interval), exp_idx_q.pop_front());
      end
    end
  end

  // kc < 0: no crossing; trip > MAXC: ramp saturates
  task automatic run_slot(input int kc, input int trip, input bit glitch, input bit do_read);
    int hit_t, rs, cap_t, exp_cnt, exp_idx;
    bit chk_ok;
    hit_t   = (kc < 0) ? cp(4) : cp(kc);
    rs      = hit_t + 1;
    exp_idx = (kc < 0) ? 4 : kc;
    exp_cnt = (trip > MAXC) ? MAXC : trip;
    cap_t   = rs + exp_cnt;
    chk_ok  = 1'b1;
    for (int t = 0; t <= cap_t + 2; t++) begin
      @(negedge clk);
      slot_start = (t == 0);
      slot_time  = TW'(t);
      row_read   = (t == 1);
      cmp_out    = 1'b0;
      ramp_count = '0;
      if (t <= hit_t) begin
        if (kc >= 0 && t == hit_t) cmp_out = 1'b1;
        else if (glitch && !is_cp(t)) cmp_out = 1'b1;
      end else begin
        ramp_count = CNT_W'((t - rs > MAXC) ? MAXC : t - rs);
        cmp_out    = (t - rs == trip);
      end
      #1;
      if (t == 1) begin
        check("R1 latch1_n preset", int'(latch1_n), 1);
        check("R1 latch2_n preset", int'(latch2_n), 1);
        check("R1 int_rst/pwr in reset", int'({int_rst, analog_pwr}), 3);
        check("R10 stale result dropped", int'(res_valid), 0);
      end
      if (t > RST && t <= hit_t && chk_en != is_cp(t)) chk_ok = 1'b0;
      if (glitch && t == hit_t)
        check("R3 glitches ignored", int'({latch1_n, int_run}), 3);
      if (t == rs) begin
        check("R4 ramp phase entered", int'({ref_ramp, int_run}), 2);
        check("R5 latch1_n/last_phase", int'({latch1_n, last_phase}),
              (kc < 0) ? 3 : 0);
        check("R11 latch2_n held in integration", int'(latch2_n), 1);
      end
      if (t == cap_t + 1) begin
        check(trip > MAXC ? "R7 saturated capture" : "R6 latch2_n fell",
              int'(latch2_n), 0);
        check("R8 power off", int'(analog_pwr), 0);
      end
      if (t == cap_t + 2) check("R9 no valid without read", int'(res_valid), 0);
    end
    check("R2 check-point enables", int'(chk_ok), 1);
    if (do_read) begin
      exp_cnt_q.push_back(exp_cnt);
      exp_idx_q.push_back(exp_idx);
      for (int s = 0; s < 3; s++) begin
        @(negedge clk);
        row_read = 1'b1; res_ready = 1'b0; #1;
        check("R9 valid under stall", int'(res_valid), 1);
        check("R9 count stable", int'(res_count), exp_cnt);
      end
      @(negedge clk);
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0; #1;
      check("R9 consumed", int'(res_valid), 0);
      row_read = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset latches", int'({latch1_n, latch2_n}), 3);
    check("R1 reset power off", int'(analog_pwr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_slot(0, 37, 1'b0, 1'b1);
    run_slot(3, 200, 1'b1, 1'b1);
    run_slot(4, 5, 1'b0, 1'b1);
    run_slot(-1, 90, 1'b1, 1'b1);
    run_slot(1, 0, 1'b0, 1'b1);
    run_slot(-1, MAXC + 100, 1'b0, 1'b1);
    run_slot(2, 12, 1'b0, 1'b0);
    run_slot(1, 3, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", exp_cnt_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule